// File: doc/BRIEF.md
# Wired-AND SCL clock synchronizer

This block produces one master's contribution to a shared open-drain SCL line, so that several masters driving the same line settle on one common clock. The bus line is sampled through a two-flop synchronizer, and the block acts only on edges it observes there. Every observed falling edge restarts the low-period count, and the line is pulled low while that count runs. When the count ends the pull is released. If another device still holds the line low, the block sits in a wait state until the line is seen high. It then counts its high period and pulls the line low again when that count ends, unless another device pulls it low first.

The net effect is that the bus low time follows the slowest low period of all masters and the bus high time follows the fastest high period. The low and high periods are 8-bit configuration values in system clock cycles. The block also emits one-cycle rise and fall strobes of the synchronized line for the data and arbitration logic. START/STOP generation and data handling are outside the block.

Top module: `scl_wand_clkgen`

## Requirements
- R1: While `enable` is low, `scl_pull` is 0 (line released) from the next clock on, whatever the line does. A reset also leaves `scl_pull`, `scl_rise` and `scl_fall` at 0.
- R2: `scl_fall` (`scl_rise`) is a one-cycle pulse that is high in the second cycle after the cycle in which `scl_in` goes low (high). Both strobes work whether or not the block is enabled.
- R3: When enabled, a `scl_fall` pulse makes `scl_pull` equal 1 (drive low) in the next cycle.
- R4: After the last `scl_fall` pulse, `scl_pull` stays 1 for exactly `low_cycles` cycles and is then released. When the block itself starts the low phase, the pull therefore lasts `low_cycles`+3 cycles, even if another device keeps the line low for longer.
- R5: After the release, the high count does not start until the synchronized line is high. With another device holding the line low for K cycles from the start of the pull, the time from one pull start to the next is max(K+1, `low_cycles`+4)+`high_cycles`+2.
- R6: Once the line is seen high, the pull starts again after `high_cycles` cycles. A master alone on the line has a released gap of `high_cycles`+3 cycles and a clock period of `low_cycles`+`high_cycles`+6 cycles.
- R7: If another device pulls the line low during the high count, the block pulls 3 cycles after that line edge, without waiting for its own count. That pull then lasts `low_cycles` cycles.
- R8: A count value of 0 behaves as 1.
- R9: When `enable` rises with the line idle high, the first pull starts `high_cycles`+2 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run the clock generator; low releases the line |
| low_cycles | input | 8 | Low-period count in clock cycles (0 treated as 1) |
| high_cycles | input | 8 | High-period count in clock cycles (0 treated as 1) |
| scl_in | input | 1 | Sampled level of the shared SCL line |
| scl_pull | output | 1 | 1 = drive SCL low, 0 = release |
| scl_rise | output | 1 | One-cycle strobe on a synchronized rising edge |
| scl_fall | output | 1 | One-cycle strobe on a synchronized falling edge |

## Verification
Every result is due a fixed number of cycles after its cause. A line edge shows on a strobe two cycles later and on `scl_pull` three cycles later. A line release restarts the pull after `high_cycles`+3 cycles, and a change of `enable` takes effect one cycle later. The bench drives inputs on falling clock edges and tracks time with a cycle counter. It measures each pull start and end against these offsets, computed by bench functions from the count values and from the length for which a second simulated master holds the line. Stretched low phases, early pulls during the high count and zero counts are all checked this way, with random counts as well as directed ones.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

  // Phases of the clock generator.
  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,  // disabled, line released
    PH_WAIT_HI = 3'd1,  // released, waiting for the line to be seen high
    PH_HIGH    = 3'd2,  // counting the high period, line released
    PH_DRIVE   = 3'd3,  // pulling low, waiting to observe the falling edge
    PH_LOW     = 3'd4   // pulling low, counting the low period
  } phase_e;

  function automatic logic phase_pulls(input phase_e ph);
    return (ph == PH_DRIVE) || (ph == PH_LOW);
  endfunction

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  assign chain_d[0] = line_in;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      assign chain_d[i] = chain_q[i-1];
    end
  endgenerate

  // Idle line is high, so reset to 1 to avoid a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[LAST];
    end
  end

  assign level = chain_q[LAST];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  assert_fall_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!level && $past(level)));

  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] lim_eff;
  logic [W-1:0] lim_m1;
  logic         cnt_en;

  // A limit of 0 counts as 1.
  assign lim_eff = (limit == '0) ? {{(W-1){1'b0}}, 1'b1} : limit;
  assign lim_m1  = lim_eff - 1'b1;
  assign expired = (cnt_q >= lim_m1);

  assign cnt_en = clr | run;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // A one-cycle period never needs a counting step.
  assert_min_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (limit <= 1) |-> !run);

endmodule

// File: rtl/scl_sync_fsm.sv
module scl_sync_fsm
  import scl_sync_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   level,
  input  logic   fall,
  input  logic   expired,
  output phase_e phase,
  output logic   cnt_clr,
  output logic   cnt_run,
  output logic   pull
);
  phase_e ph_q;
  phase_e ph_d;

  always_comb begin
    ph_d    = ph_q;
    cnt_clr = 1'b1;
    cnt_run = 1'b0;
    if (!en) begin
      ph_d = PH_OFF;
    end else begin
      case (ph_q)
        PH_OFF: ph_d = PH_WAIT_HI;
        PH_WAIT_HI: begin
          if (fall)       ph_d = PH_LOW;
          else if (level) ph_d = PH_HIGH;
        end
        PH_HIGH: begin
          if (fall)         ph_d = PH_LOW;
          else if (expired) ph_d = PH_DRIVE;
          else begin
            cnt_clr = 1'b0;
            cnt_run = 1'b1;
          end
        end
        PH_DRIVE: begin
          if (fall) ph_d = PH_LOW;
        end
        PH_LOW: begin
          if (fall) begin
            ph_d = PH_LOW;            // restart the low count
          end else if (expired) begin
            ph_d = PH_WAIT_HI;
          end else begin
            cnt_clr = 1'b0;
            cnt_run = 1'b1;
          end
        end
        default: ph_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_OFF;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
  assign pull  = phase_pulls(ph_q);

  assert_release_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pull);

  assert_fall_grabs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fall && ph_q != PH_OFF) |=> pull);

  assert_low_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ph_q == PH_LOW && expired && !fall) |=> !pull);

  assert_wait_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ph_q == PH_WAIT_HI && !level && !fall) |=> (!pull && ph_q == PH_WAIT_HI));

  assert_high_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ph_q == PH_WAIT_HI && level && !fall) |=> (ph_q == PH_HIGH));

  assert_high_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ph_q == PH_HIGH && expired && !fall) |=> pull);

  assert_enable_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ph_q == PH_OFF) |=> (ph_q == PH_WAIT_HI && !pull));

endmodule

// File: rtl/scl_wand_clkgen.sv
module scl_wand_clkgen
  import scl_sync_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] low_cycles,
  input  logic [CNT_W-1:0] high_cycles,
  input  logic             scl_in,
  output logic             scl_pull,
  output logic             scl_rise,
  output logic             scl_fall
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n;

  // Assert asynchronously, release on a clock edge.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[RST_STAGES-1];

  logic             line_level;
  logic             line_rise;
  logic             line_fall;
  logic             cnt_clr;
  logic             cnt_run;
  logic             cnt_expired;
  logic [CNT_W-1:0] cnt_limit;
  phase_e           phase;

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (scl_in),
    .level   (line_level),
    .rise    (line_rise),
    .fall    (line_fall)
  );

  // One counter serves both phases; the limit follows the phase.
  assign cnt_limit = (phase == PH_HIGH) ? high_cycles : low_cycles;

  scl_phase_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .run     (cnt_run),
    .limit   (cnt_limit),
    .expired (cnt_expired)
  );

  scl_sync_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .level   (line_level),
    .fall    (line_fall),
    .expired (cnt_expired),
    .phase   (phase),
    .cnt_clr (cnt_clr),
    .cnt_run (cnt_run),
    .pull    (scl_pull)
  );

  assign scl_rise = line_rise;
  assign scl_fall = line_fall;

endmodule

// File: tb/tb_scl_wand_clkgen.sv
module tb_scl_wand_clkgen;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       enable;
  logic [7:0] low_cycles;
  logic [7:0] high_cycles;
  logic       other_pull;
  logic       scl_pull;
  logic       scl_rise;
  logic       scl_fall;
  logic       bus;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // Wired-AND line with a second simulated master.
  assign bus = !(scl_pull || other_pull);

  scl_wand_clkgen dut (
    .clk         (clk),
    .arst_n      (arst_n),
    .enable      (enable),
    .low_cycles  (low_cycles),
    .high_cycles (high_cycles),
    .scl_in      (bus),
    .scl_pull    (scl_pull),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction
  function automatic int exp_first(input int h);   return eff(h) + 2; endfunction
  function automatic int exp_width(input int l);   return eff(l) + 3; endfunction
  function automatic int exp_gap(input int h);     return eff(h) + 3; endfunction
  function automatic int exp_period(input int l, input int h);
    return eff(l) + eff(h) + 6;
  endfunction
  function automatic int exp_stretch(input int l, input int h, input int k);
    int a;
    a = k + 1;
    if (eff(l) + 4 > a) a = eff(l) + 4;
    return a + eff(h) + 2;
  endfunction

  // Steps on falling edges until scl_pull equals v; returns the cycle count.
  task automatic wait_for(input logic v, output int t);
    int guard = 0;
    while (scl_pull !== v && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) check(1'b0, "wait_for timeout", guard, 2000);
    t = cyc;
  endtask

  task automatic run_solo(input int l, input int h);
    int t_en, t0, t1, t2, t3;
    enable = 1'b0;
    other_pull = 1'b0;
    @(negedge clk);
    low_cycles  = 8'(l);
    high_cycles = 8'(h);
    repeat (6) @(negedge clk);
    enable = 1'b1;
    t_en = cyc;
    wait_for(1'b1, t0);
    check(t0 - t_en == exp_first(h), "R9 first pull after enable", t0 - t_en, exp_first(h));
    wait_for(1'b0, t1);
    check(t1 - t0 == exp_width(l), "R4 solo pull width", t1 - t0, exp_width(l));
    wait_for(1'b1, t2);
    check(t2 - t1 == exp_gap(h), "R6 solo released gap", t2 - t1, exp_gap(h));
    wait_for(1'b0, t3);
    check(t3 - t1 == exp_period(l, h), "R6 solo period", t3 - t1, exp_period(l, h));
    if (l == 0 || h == 0)
      check(t3 - t1 == 8 + eff(l) - 1 + eff(h) - 1, "R8 zero count as one",
            t3 - t1, 8 + eff(l) - 1 + eff(h) - 1);
  endtask

  task automatic run_stretch(input int l, input int h, input int k);
    int ta, tf, tn;
    wait_for(1'b1, ta);
    other_pull = 1'b1;
    tf = -1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (tf < 0 && !scl_pull) tf = cyc;
    end
    other_pull = 1'b0;
    if (tf < 0) wait_for(1'b0, tf);
    check(tf - ta == exp_width(l), "R4 own release under stretch", tf - ta, exp_width(l));
    wait_for(1'b1, tn);
    check(tn - ta == exp_stretch(l, h, k), "R5 stretched period", tn - ta,
          exp_stretch(l, h, k));
  endtask

  task automatic run_early(input int l, input int d);
    int tr, ts, t1, t2;
    wait_for(1'b1, tr);
    wait_for(1'b0, tr);
    repeat (d) @(negedge clk);
    other_pull = 1'b1;
    ts = cyc;
    wait_for(1'b1, t1);
    check(t1 - ts == 3, "R7 early pull delay", t1 - ts, 3);
    check(tr < ts, "R3 pull follows observed fall", ts - tr, d);
    @(negedge clk);
    other_pull = 1'b0;
    wait_for(1'b0, t2);
    check(t2 - t1 == eff(l), "R7 early pull width", t2 - t1, eff(l));
  endtask

  initial begin
    int l, h, k, d;
    arst_n = 1'b0;
    enable = 1'b0;
    low_cycles = 8'd5;
    high_cycles = 8'd5;
    other_pull = 1'b0;
    repeat (3) @(negedge clk);
    check(scl_pull == 1'b0, "R1 reset pull", int'(scl_pull), 0);
    check(scl_rise == 1'b0 && scl_fall == 1'b0, "R1 reset strobes",
          int'({scl_rise, scl_fall}), 0);
    arst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(scl_pull == 1'b0, "R1 idle after reset", int'(scl_pull), 0);

    // R2: strobe timing while disabled; R1: no pull meanwhile.
    other_pull = 1'b1;
    @(negedge clk);
    check(scl_fall == 1'b0, "R2 fall not yet", int'(scl_fall), 0);
    @(negedge clk);
    check(scl_fall == 1'b1, "R2 fall strobe", int'(scl_fall), 1);
    @(negedge clk);
    check(scl_fall == 1'b0, "R2 fall one cycle", int'(scl_fall), 0);
    check(scl_pull == 1'b0, "R1 disabled ignores fall", int'(scl_pull), 0);
    other_pull = 1'b0;
    @(negedge clk);
    check(scl_rise == 1'b0, "R2 rise not yet", int'(scl_rise), 0);
    @(negedge clk);
    check(scl_rise == 1'b1, "R2 rise strobe", int'(scl_rise), 1);
    @(negedge clk);
    check(scl_rise == 1'b0, "R2 rise one cycle", int'(scl_rise), 0);

    // Directed cases.
    run_solo(3, 5);
    run_solo(0, 0);
    run_solo(255, 2);
    run_solo(4, 6);
    run_stretch(4, 6, 20);
    run_stretch(4, 6, 2);
    run_early(4, 3);
    run_solo(1, 8);
    run_early(1, 7);
    run_stretch(1, 8, 9);

    // Random counts and stretch/early patterns.
    void'($urandom(32'd20250611));
    for (int it = 0; it < 12; it++) begin
      l = 1 + int'($urandom % 20);
      h = 4 + int'($urandom % 20);
      k = int'($urandom % 40);
      d = 2 + int'($urandom % (h - 2));
      run_solo(l, h);
      run_stretch(l, h, k);
      run_early(l, d);
    end

    // R1: disabling during the pull releases the line next cycle.
    wait_for(1'b1, l);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl_pull == 1'b0, "R1 release on disable", int'(scl_pull), 0);
    other_pull = 1'b1;
    repeat (6) @(negedge clk);
    check(scl_pull == 1'b0, "R1 stays released", int'(scl_pull), 0);
    other_pull = 1'b0;
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end

endmodule